// File: doc/BRIEF.md
# Clock Configuration Register Slave on a Two-Wire Bus

This block lets a host set up a clock synthesizer through a small bank of
8-bit configuration registers over an SMBus-compatible two-wire link. SCLK
and SDATA reach it as open-drain lines. Each line arrives as a sampled input,
and the block can pull SDATA low through one enable output. Both lines are
re-timed onto a faster system clock. All decoding runs in that clock domain.
The register contents leave the block as one flat vector of control bits,
for example the per-output enables.

Each transaction opens with the device address. A command byte follows it.
The top bit of the command byte picks the transfer type. When it is 1, the
transfer is an indexed single-register access, and the low seven bits give
the register offset. When it is 0, the transfer is a sequential block access
that starts at register 0. It opens with a byte count and then moves upward
one register per byte. The host may stop a block transfer after any whole
byte, and the registers written up to that point keep their new values.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read), that is 7-bit address 0x69. For any other address it leaves SDATA released during the acknowledge clock.
- R2: A write whose command byte has bit 7 = 1 updates only the register whose index is in command bits 6:0. Every other register keeps its value.
- R3: A byte read (command bit 7 = 1, then a repeated START and 0xD3) returns the register at the offset in bits 6:0. Bits are shifted most significant first.
- R4: A block write (command 0x00) takes the next byte as a count and discards it. Each following data byte goes to register 0, 1, 2 and so on. A STOP after any whole byte keeps every register written so far.
- R5: A block read (command 0x00, repeated START, 0xD3) first returns a count equal to the register total (0x08). It then returns register 0, register 1 and so on. After the host answers a byte with NACK, the slave leaves SDATA released.
- R6: With 8 registers, a write to any offset from 8 to 127 is acknowledged and changes no register. A read from such an offset returns 0x00.
- R7: After reset, sda_oe is 0 and the registers hold their defaults. With the default parameters cfg_out equals 64'h8765_4321_0FED_CBA9, with register 0 in bits 7:0.
- R8: The slave acknowledges the command byte and every data byte the host writes, including the count byte and bytes that are ignored.
- R9: A START or STOP detected at any point abandons the byte in progress without writing it. The next transaction is then decoded normally.
- R10: sda_oe changes only while SCLK is low, so that the slave never creates a START or STOP by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset, used as power-up reset |
| scl_i | input | 1 | Sampled level of the SCLK line |
| sda_i | input | 1 | Sampled level of the SDATA line |
| sda_oe | output | 1 | When 1, drive SDATA low |
| cfg_out | output | NUM_REGS*8 | Register bank contents, register i in bits 8i+7:8i |

## Verification
The hardest case to reach is a STOP that arrives in the middle of a data
byte. The slave must throw away the partly shifted byte, and the bus must
still be usable afterwards. The bench reaches it with a byte write whose
data phase is cut after four clocks by a STOP. It then checks that the
target register still holds its old value and that a complete transfer
right after it works. The repeated START inside a read is a second hard
case. It is reached both after a byte-mode command and after a block-mode
command, so that both pointer set-ups are used.

// File: rtl/clkcfg_pkg.sv
// Package for the clock configuration slave. It holds the protocol state
// encodings and the width of the register pointer.
// Assumption: at most 128 registers, because the command offset has 7 bits.
package clkcfg_pkg;

    localparam int PTR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } smb_state_t;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_CMD,
        RL_DATA
    } smb_role_t;

endpackage

// File: rtl/smb_line_sync.sv
// Re-times SCLK and SDATA onto the system clock and finds the bus events on them.
// Assumption: both lines idle high; the event outputs are single-cycle pulses.
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_d, sda_d;

    // Two-flop synchronisers plus one delayed copy of each line for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    // Edge and bus-condition decode on the re-timed levels.
    always_comb begin
        scl_s     = scl_ff[1];
        sda_s     = sda_ff[1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/cfg_reg_bank.sv
// Register bank holding the configuration bytes, with one write port and one
// read port.
// Assumption: an index at or beyond NUM_REGS writes nothing and reads 0x00.
module cfg_reg_bank #(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = 64'h8765_4321_0FED_CBA9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [clkcfg_pkg::PTR_W-1:0] wr_idx,
    input  logic [7:0]                  wr_data,
    input  logic [clkcfg_pkg::PTR_W-1:0] rd_idx,
    output logic [7:0]                  rd_data,
    output logic [NUM_REGS*8-1:0]       cfg_out
);
    import clkcfg_pkg::*;

    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // One configuration byte, loaded with its default at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= DEFAULTS[i*8 +: 8];
            else if (wr_en && wr_idx == PTR_W'(i))
                regs[i] <= wr_data;
        end
        assign cfg_out[i*8 +: 8] = regs[i];
    end

    // Read mux; an index outside the bank gives zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == PTR_W'(i))
                rd_data = regs[i];
    end
endmodule

// File: rtl/smb_proto_fsm.sv
// Byte-level protocol engine. It shifts bits in and out, matches the address,
// drives acknowledges, decodes the command byte and steps the register pointer.
// Assumption: the inputs come from smb_line_sync; SDATA is changed only after a
// re-timed SCLK fall; START and STOP take priority over everything else.
module smb_proto_fsm #(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sda_s,
    input  logic                         scl_rise,
    input  logic                         scl_fall,
    input  logic                         start_det,
    input  logic                         stop_det,
    input  logic [7:0]                   rd_data,
    output logic                         sda_oe,
    output logic                         wr_en,
    output logic [clkcfg_pkg::PTR_W-1:0] wr_idx,
    output logic [7:0]                   wr_data,
    output logic [clkcfg_pkg::PTR_W-1:0] rd_idx
);
    import clkcfg_pkg::*;

    localparam logic [PTR_W-1:0] PTR_DEAD = '1;

    smb_state_t       state;
    smb_role_t        role;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             is_read;
    logic             byte_mode;
    logic [6:0]       cmd_off;
    logic [PTR_W-1:0] ptr;
    logic             cnt_pend;
    logic             m_nack;
    logic [7:0]       tx_byte;
    logic [PTR_W-1:0] ptr_adv;

    // Next outgoing byte and the pointer after one access.
    always_comb begin
        tx_byte = cnt_pend ? 8'(NUM_REGS) : rd_data;
        if (byte_mode || ptr == PTR_DEAD)
            ptr_adv = PTR_DEAD;
        else
            ptr_adv = ptr + 1'b1;
        rd_idx = ptr;
    end

    // Protocol sequencer: one step per re-timed SCLK edge or bus condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            role      <= RL_ADDR;
            bit_cnt   <= '0;
            shreg     <= '0;
            is_read   <= 1'b0;
            byte_mode <= 1'b0;
            cmd_off   <= '0;
            ptr       <= '0;
            cnt_pend  <= 1'b0;
            m_nack    <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_RX;
                role    <= RL_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            state  <= ST_ACK;
                            sda_oe <= 1'b1;
                            case (role)
                                RL_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        is_read  <= shreg[0];
                                        ptr      <= byte_mode ? {1'b0, cmd_off} : '0;
                                        cnt_pend <= ~byte_mode;
                                    end else begin
                                        state  <= ST_IDLE;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                RL_CMD: begin
                                    byte_mode <= shreg[7];
                                    cmd_off   <= shreg[6:0];
                                    ptr       <= shreg[7] ? {1'b0, shreg[6:0]} : '0;
                                    cnt_pend  <= ~shreg[7];
                                end
                                default: begin
                                    if (cnt_pend) begin
                                        cnt_pend <= 1'b0;
                                    end else begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= ptr;
                                        wr_data <= shreg;
                                        ptr     <= ptr_adv;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (role == RL_ADDR && is_read) begin
                                state  <= ST_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                if (cnt_pend) cnt_pend <= 1'b0;
                                else          ptr      <= ptr_adv;
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                                role   <= (role == RL_ADDR) ? RL_CMD : RL_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                state  <= ST_RACK;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_nack <= sda_s;
                        end else if (scl_fall) begin
                            if (m_nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_TX;
                                bit_cnt <= '0;
                                shreg   <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                                if (cnt_pend) cnt_pend <= 1'b0;
                                else          ptr      <= ptr_adv;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/clkcfg_smb_slave.sv
// Top of the clock configuration slave: line synchroniser, protocol engine
// and register bank.
// Assumption: clk runs at least about 8 times faster than SCLK; the open-drain
// pad (drive low while sda_oe is 1) sits outside this block.
module clkcfg_smb_slave #(
    parameter int                    NUM_REGS = 8,
    parameter logic [6:0]            DEV_ADDR = 7'h69,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = 64'h8765_4321_0FED_CBA9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_out
);
    import clkcfg_pkg::*;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    smb_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_proto_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg_out (cfg_out)
    );
endmodule

// File: rtl/clkcfg_smb_chk.sv
// Property checker for clkcfg_smb_slave. It is attached with the bind below and
// watches the re-timed bus events, the drive enable and the bank write port.
// Assumption: it only observes and drives nothing.
module clkcfg_smb_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         scl_s,
    input logic                         start_det,
    input logic                         stop_det,
    input logic                         sda_oe,
    input logic                         wr_en,
    input logic [clkcfg_pkg::PTR_W-1:0] wr_idx,
    input logic [NUM_REGS*8-1:0]        cfg_out
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe))
        else $error("sda_oe moved while SCLK was high");

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe)
        else $error("SDATA still driven after STOP");

    // R6
    oor_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= clkcfg_pkg::PTR_W'(NUM_REGS)) |=> $stable(cfg_out))
        else $error("out-of-range write changed the bank");

    // R2
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_out))
        else $error("bank changed without a write strobe");
endmodule

bind clkcfg_smb_slave clkcfg_smb_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .cfg_out   (cfg_out)
);

// File: tb/clkcfg_smb_slave_tb_top.sv
// Self-checking bench: it models the bus master and the open-drain wiring
// and predicts the register bank contents.
module clkcfg_smb_slave_tb_top;
    localparam int          Q        = 6;
    localparam logic [63:0] DEF_CFG  = 64'h8765_4321_0FED_CBA9;
    localparam logic [23:0] VEC [4] = '{
        {8'h83, 8'h5A, 8'h5A},
        {8'h80, 8'h00, 8'h00},
        {8'h87, 8'hC3, 8'hC3},
        {8'h8A, 8'h77, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        sda_oe;
    logic [63:0] cfg_out;
    logic        sda_line;
    logic [63:0] exp_cfg;
    logic        mon_en = 1'b0;
    int          checks = 0;
    int          failures = 0;
    int          viol = 0;

    assign sda_line = ~(m_sda_low | sda_oe);

    always #4 clk = ~clk;

    clkcfg_smb_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .cfg_out (cfg_out)
    );

    // R10 monitor: the slave may only change its drive while SCLK is low.
    always @(sda_oe) if (mon_en && m_scl) viol++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0;     wq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b0; wq(); wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda_low = ~b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        m_sda_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wq();
            m_scl = 1'b1; wq();
            b = {b[6:0], sda_line}; wq();
            m_scl = 1'b0;
        end
        wq();
        m_sda_low = ~nack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda_low = 1'b0;
    endtask

    task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(cmd, a1);
        send_byte(d, a2);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(cmd, a1);
        bus_start();
        send_byte(8'hD3, a2);
        recv_byte(d, 1'b1);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic       ok, a0, a1, a2;
        logic [7:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        mon_en = 1'b1;

        // R7 reset state
        chk("R7 cfg_out after reset", cfg_out, DEF_CFG);
        chk("R7 sda_oe after reset", {63'd0, sda_oe}, 64'd0);
        exp_cfg = DEF_CFG;

        // R2 R3 R6 table walk: byte write, byte read, bank compare
        for (int v = 0; v < 4; v++) begin
            logic [7:0] cmd, wd, ex;
            {cmd, wd, ex} = VEC[v];
            byte_write(cmd, wd, ok);
            chk("R8 byte write acks", {63'd0, ok}, 64'd1);
            if (cmd[6:0] < 7'd8) exp_cfg[cmd[2:0]*8 +: 8] = wd;
            chk("R2 R6 bank after byte write", cfg_out, exp_cfg);
            byte_read(cmd, rd, ok);
            chk("R3 R6 byte read data", {56'd0, rd}, {56'd0, ex});
            chk("R1 read address acked", {63'd0, ok}, 64'd1);
        end

        // R1 foreign address is not acknowledged
        bus_start();
        send_byte(8'hA0, a0);
        bus_stop();
        chk("R1 foreign address ack", {63'd0, a0}, 64'd0);

        // R4 block write of three bytes, early STOP
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a1);
        send_byte(8'h03, a2);
        chk("R8 block cmd/count acks", {62'd0, a1, a2}, 64'd3);
        send_byte(8'h11, a0);
        send_byte(8'h22, a1);
        send_byte(8'h33, a2);
        bus_stop();
        chk("R8 block data acks", {61'd0, a0, a1, a2}, 64'd7);
        exp_cfg[23:0] = 24'h332211;
        chk("R4 bank after block write", cfg_out, exp_cfg);

        // R5 block read: count then registers 0..2, NACK on last
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a1);
        bus_start();
        send_byte(8'hD3, a2);
        recv_byte(rd, 1'b0);
        chk("R5 block read count", {56'd0, rd}, 64'h08);
        for (int k = 0; k < 3; k++) begin
            recv_byte(rd, k == 2);
            chk("R5 block read data", {56'd0, rd}, {56'd0, exp_cfg[k*8 +: 8]});
        end
        wq();
        chk("R5 released after NACK", {63'd0, sda_oe}, 64'd0);
        bus_stop();

        // R9 STOP in the middle of a data byte
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h85, a1);
        send_bits(8'h00, 4);
        bus_stop();
        chk("R9 aborted byte not written", cfg_out, exp_cfg);
        byte_write(8'h85, 8'hE1, ok);
        exp_cfg[47:40] = 8'hE1;
        chk("R9 transfer after abort", cfg_out, exp_cfg);

        // R10 drive only changed while SCLK low
        chk("R10 sda_oe edges with SCLK high", viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule